// File: doc/BRIEF.md
# Management Override Lock for PHY Status and Identity Registers

This block holds the extended control register of an Ethernet PHY management register file, together with the two identifier registers and the software-visible view of the status register. It sits behind a management frame decoder, which hands it an already decoded register index, write data and a write strobe. It returns read data for the same index in the same cycle.

The status and identifier registers are normally locked against writes. Setting the override enable bit in the extended control register opens exactly one write into register 1, 2 or 3. That write closes the window again by clearing the enable. The same window is the only way to move the 5-bit management address. The address is taken from strap pins at reset and is driven out so that the frame decoder can match incoming frames. Three plain control bits drive the far-end fault enable, the far-end fault transmit and the invalid-code test outputs.

Top module: `phy_mgmt_ovr`

## Requirements
- R1: After reset, register 16 reads `{1'b0, 4'b0, strapAddr, 1'b0, 3'b100, 2'b00}` (bit 15 override = 0, bits 10:6 = strap address, bit 4 = 1, bits 3 and 2 = 0), and `phyAddr` equals `strapAddr`.
- R2: A write to register 16 sets bits 4, 3 and 2 from write data. The outputs `farFaultEn` (bit 4), `farFaultTx` (bit 3) and `badCodeTest` (bit 2) follow on the next cycle. Bits 14:11, 5, 1 and 0 always read 0.
- R3: While bit 15 of register 16 is 0, writes to registers 1, 2 and 3 change neither the target register nor bit 15.
- R4: While bit 15 is 1, a write to register 2 or 3 stores any 16-bit value.
- R5: While bit 15 is 1, a write to register 1 changes only the bits in `STATUS_OVR_MASK` (default bits 15:11 and 6:1). Bits outside the mask always read the live `statusLive` input.
- R6: The first write to register 1, 2 or 3 while bit 15 is 1 clears bit 15, so the next such write is ignored.
- R7: Bits 10:6 of register 16 change only on a write to register 16 made while bit 15 is already 1. `phyAddr` shows the new value from the next cycle on. Writing register 16 does not clear bit 15 unless the written bit 15 is 0.
- R8: Reads of any index other than 1, 2, 3 and 16 return 0. Writes to such indices change no register and do not consume the override.
- R9: `rdData` reflects the register selected by `regAddr` combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| strapAddr | input | 5 | Management address straps, sampled during reset |
| statusLive | input | 16 | Live status bits from the PHY core |
| wrEn | input | 1 | Write strobe for the decoded register access |
| regAddr | input | 5 | Decoded register index for read and write |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `regAddr` |
| phyAddr | output | 5 | Current management address |
| farFaultEn | output | 1 | Far-end fault enable |
| farFaultTx | output | 1 | Transmit far-end fault |
| badCodeTest | output | 1 | Invalid-code test enable |

## Verification
The bench builds the block with the default status mask. It uses non-zero identifier reset values (16'h0022 and 16'h5610) and a status reset value of 16'h7800. These let a lost or spurious write show up as a mismatch against a known non-trivial pattern, not against zero. The strap value 19 puts ones in both ends of the address field, which exposes a misplaced or truncated address slice. The live status pattern sets bits both inside and outside the mask, so a single read shows whether the masked merge is correct.

// File: rtl/pmo_pkg.sv
package pmo_pkg;
  localparam int DW = 16;
  localparam int AW = 5;
  localparam int PAW = 5;

  localparam logic [AW-1:0] RA_STATUS = 5'd1;
  localparam logic [AW-1:0] RA_ID1    = 5'd2;
  localparam logic [AW-1:0] RA_ID2    = 5'd3;
  localparam logic [AW-1:0] RA_EXT    = 5'd16;

  localparam int OVR_BIT   = 15;
  localparam int ADDR_LSB  = 6;
  localparam int FEF_BIT   = 4;
  localparam int FEFTX_BIT = 3;
  localparam int BAD_BIT   = 2;

  localparam logic [DW-1:0] EXT_RSVD_MASK = 16'h7823;

  typedef struct packed {
    logic wrExt;
    logic wrStatus;
    logic wrId1;
    logic wrId2;
    logic addrLoad;
  } pmoStb_t;
endpackage

// File: rtl/pmo_ctrl.sv
module pmo_ctrl
  import pmo_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] regAddr,
  input  logic          ovrReq,
  output pmoStb_t       stb,
  output logic          ovrActive
);
  logic ovrQ;
  logic hitLocked;

  always_comb begin
    hitLocked    = (regAddr == RA_STATUS) || (regAddr == RA_ID1) || (regAddr == RA_ID2);
    stb.wrExt    = wrEn && (regAddr == RA_EXT);
    stb.wrStatus = wrEn && ovrQ && (regAddr == RA_STATUS);
    stb.wrId1    = wrEn && ovrQ && (regAddr == RA_ID1);
    stb.wrId2    = wrEn && ovrQ && (regAddr == RA_ID2);
    stb.addrLoad = wrEn && ovrQ && (regAddr == RA_EXT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) ovrQ <= 1'b0;
    else if (stb.wrExt) ovrQ <= ovrReq;
    else if (wrEn && ovrQ && hitLocked) ovrQ <= 1'b0;
  end

  assign ovrActive = ovrQ;

  AST_OVR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ovrQ && hitLocked) |=> !ovrQ); // R6
  AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !ovrQ && hitLocked) |=> !ovrQ); // R3
  AST_UNIMPL_KEEPS_OVR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !hitLocked && (regAddr != RA_EXT)) |=> $stable(ovrQ)); // R8
endmodule

// File: rtl/pmo_dpath.sv
module pmo_dpath
  import pmo_pkg::*;
#(
  parameter logic [DW-1:0] STATUS_OVR_MASK = 16'hF87E,
  parameter logic [DW-1:0] STATUS_INIT     = 16'h0000,
  parameter logic [DW-1:0] ID1_INIT        = 16'h0000,
  parameter logic [DW-1:0] ID2_INIT        = 16'h0000
)(
  input  logic           clk,
  input  logic           rstN,
  input  pmoStb_t        stb,
  input  logic           ovrActive,
  input  logic [PAW-1:0] strapAddr,
  input  logic [DW-1:0]  statusLive,
  input  logic [AW-1:0]  regAddr,
  input  logic [DW-1:0]  wrData,
  output logic [DW-1:0]  rdData,
  output logic [PAW-1:0] phyAddr,
  output logic           farFaultEn,
  output logic           farFaultTx,
  output logic           badCodeTest
);
  logic [PAW-1:0] addrQ;
  logic [DW-1:0]  id1Q, id2Q, statusQ;
  logic           fefQ, fefTxQ, badQ;
  logic [DW-1:0]  extView, statusView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= strapAddr;
      fefQ   <= 1'b1;
      fefTxQ <= 1'b0;
      badQ   <= 1'b0;
    end else begin
      if (stb.wrExt) begin
        fefQ   <= wrData[FEF_BIT];
        fefTxQ <= wrData[FEFTX_BIT];
        badQ   <= wrData[BAD_BIT];
      end
      if (stb.addrLoad) addrQ <= wrData[ADDR_LSB +: PAW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      id1Q    <= ID1_INIT;
      id2Q    <= ID2_INIT;
      statusQ <= STATUS_INIT & STATUS_OVR_MASK;
    end else begin
      if (stb.wrId1) id1Q <= wrData;
      if (stb.wrId2) id2Q <= wrData;
      if (stb.wrStatus) statusQ <= wrData & STATUS_OVR_MASK;
    end
  end

  always_comb begin
    extView = '0;
    extView[OVR_BIT]              = ovrActive;
    extView[ADDR_LSB +: PAW]      = addrQ;
    extView[FEF_BIT]              = fefQ;
    extView[FEFTX_BIT]            = fefTxQ;
    extView[BAD_BIT]              = badQ;
    statusView = (statusQ & STATUS_OVR_MASK) | (statusLive & ~STATUS_OVR_MASK);
    case (regAddr)
      RA_STATUS: rdData = statusView;
      RA_ID1:    rdData = id1Q;
      RA_ID2:    rdData = id2Q;
      RA_EXT:    rdData = extView;
      default:   rdData = '0;
    endcase
  end

  assign phyAddr     = addrQ;
  assign farFaultEn  = fefQ;
  assign farFaultTx  = fefTxQ;
  assign badCodeTest = badQ;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.addrLoad |=> $stable(phyAddr)); // R7
  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    stb.addrLoad |=> (phyAddr == $past(wrData[ADDR_LSB +: PAW]))); // R7
  AST_ID1_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrId1 |=> $stable(id1Q)); // R3
  AST_ID2_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrId2 |=> (id2Q == $past(wrData))); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == RA_EXT) |-> ((rdData & EXT_RSVD_MASK) == '0)); // R2
  AST_LIVE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == RA_STATUS) |-> ((rdData & ~STATUS_OVR_MASK) == (statusLive & ~STATUS_OVR_MASK))); // R5
endmodule

// File: rtl/phy_mgmt_ovr.sv
module phy_mgmt_ovr
  import pmo_pkg::*;
#(
  parameter logic [15:0] STATUS_OVR_MASK = 16'hF87E,
  parameter logic [15:0] STATUS_INIT     = 16'h0000,
  parameter logic [15:0] ID1_INIT        = 16'h0000,
  parameter logic [15:0] ID2_INIT        = 16'h0000
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic [4:0]  strapAddr,
  input  logic [15:0] statusLive,
  input  logic        wrEn,
  input  logic [4:0]  regAddr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic [4:0]  phyAddr,
  output logic        farFaultEn,
  output logic        farFaultTx,
  output logic        badCodeTest
);
  pmoStb_t stb;
  logic    ovrActive;

  pmo_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .regAddr   (regAddr),
    .ovrReq    (wrData[OVR_BIT]),
    .stb       (stb),
    .ovrActive (ovrActive)
  );

  pmo_dpath #(
    .STATUS_OVR_MASK (STATUS_OVR_MASK),
    .STATUS_INIT     (STATUS_INIT),
    .ID1_INIT        (ID1_INIT),
    .ID2_INIT        (ID2_INIT)
  ) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .ovrActive   (ovrActive),
    .strapAddr   (strapAddr),
    .statusLive  (statusLive),
    .regAddr     (regAddr),
    .wrData      (wrData),
    .rdData      (rdData),
    .phyAddr     (phyAddr),
    .farFaultEn  (farFaultEn),
    .farFaultTx  (farFaultTx),
    .badCodeTest (badCodeTest)
  );
endmodule

// File: tb/phy_mgmt_ovr_tb_top.sv
`timescale 1ns/1ps
module phy_mgmt_ovr_tb_top;
  localparam logic [15:0] MASK  = 16'hF87E;
  localparam logic [15:0] SINIT = 16'h7800;
  localparam logic [15:0] I1    = 16'h0022;
  localparam logic [15:0] I2    = 16'h5610;
  localparam logic [4:0]  STRAP = 5'd19;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0]  strapAddr = STRAP;
  logic [15:0] statusLive = 16'h0405;
  logic wrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [4:0]  phyAddr;
  logic farFaultEn, farFaultTx, badCodeTest;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  phy_mgmt_ovr #(.STATUS_OVR_MASK(MASK), .STATUS_INIT(SINIT),
                 .ID1_INIT(I1), .ID2_INIT(I2)) dut_i (
    .clk(clk), .rstN(rstN), .strapAddr(strapAddr), .statusLive(statusLive),
    .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData), .rdData(rdData),
    .phyAddr(phyAddr), .farFaultEn(farFaultEn), .farFaultTx(farFaultTx),
    .badCodeTest(badCodeTest));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = rdData;
  endtask

  function automatic logic [15:0] extExp(input logic ovr, input logic [4:0] ad, input logic [2:0] c);
    return {ovr, 4'b0, ad, 1'b0, c, 2'b00};
  endfunction

  function automatic logic [15:0] statExp(input logic [15:0] stored, input logic [15:0] live);
    return (stored & MASK) | (live & ~MASK);
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    rd(5'd16, v); check("R1 ext reset", v, extExp(1'b0, STRAP, 3'b100));
    check("R1 phyAddr reset", {11'b0, phyAddr}, {11'b0, STRAP});
    rd(5'd2, v); check("R1 id1 reset", v, I1);
  endtask

  task automatic t_ctrl_bits();
    logic [15:0] v;
    wr(5'd16, 16'h781F);
    rd(5'd16, v); check("R2 ext ctrl bits, reserved zero", v, extExp(1'b0, STRAP, 3'b111));
    check("R2 outputs", {13'b0, farFaultEn, farFaultTx, badCodeTest}, 16'h0007);
    wr(5'd16, 16'h0008);
    check("R2 outputs partial", {13'b0, farFaultEn, farFaultTx, badCodeTest}, 16'h0002);
    check("R7 addr kept without override", {11'b0, phyAddr}, {11'b0, STRAP});
  endtask

  task automatic t_locked();
    logic [15:0] v;
    wr(5'd2, 16'hDEAD); wr(5'd3, 16'hBEEF); wr(5'd1, 16'hFFFF);
    rd(5'd2, v); check("R3 id1 locked", v, I1);
    rd(5'd3, v); check("R3 id2 locked", v, I2);
    rd(5'd1, v); check("R3 status locked", v, statExp(SINIT, statusLive));
    rd(5'd16, v); check("R3 override stays clear", v[15:0], extExp(1'b0, STRAP, 3'b010));
  endtask

  task automatic t_oneshot_id();
    logic [15:0] v;
    wr(5'd16, 16'h8008);
    rd(5'd16, v); check("R6 override set", {15'b0, v[15]}, 16'h0001);
    wr(5'd3, 16'hA5C3);
    rd(5'd3, v); check("R4 id2 any value", v, 16'hA5C3);
    rd(5'd16, v); check("R6 override cleared", {15'b0, v[15]}, 16'h0000);
    wr(5'd3, 16'h1111);
    rd(5'd3, v); check("R6 second write ignored", v, 16'hA5C3);
    wr(5'd16, 16'h8008);
    wr(5'd2, 16'h0000);
    rd(5'd2, v); check("R4 id1 any value", v, 16'h0000);
  endtask

  task automatic t_status();
    logic [15:0] v;
    wr(5'd16, 16'h8008);
    wr(5'd1, 16'hFFFF);
    rd(5'd1, v); check("R5 status masked write", v, statExp(16'hFFFF, 16'h0405));
    statusLive = 16'h0000;
    rd(5'd1, v); check("R5 unmasked bits follow live", v, statExp(16'hFFFF, 16'h0000));
    statusLive = 16'hFFFF;
    rd(5'd1, v); check("R9 read is same cycle", v, 16'hFFFF);
  endtask

  task automatic t_addr();
    logic [15:0] v;
    wr(5'd16, 16'h8008);
    wr(5'd16, extExp(1'b1, 5'd7, 3'b000));
    check("R7 phyAddr updated", {11'b0, phyAddr}, 16'd7);
    rd(5'd16, v); check("R7 override kept by ext write", v, extExp(1'b1, 5'd7, 3'b000));
    wr(5'd16, extExp(1'b0, 5'd7, 3'b100));
    wr(5'd16, extExp(1'b0, 5'd30, 3'b100));
    check("R7 addr locked again", {11'b0, phyAddr}, 16'd7);
  endtask

  task automatic t_unimpl();
    logic [15:0] v;
    wr(5'd16, extExp(1'b1, 5'd7, 3'b100));
    wr(5'd5, 16'hFFFF);
    rd(5'd5, v); check("R8 unimplemented reads zero", v, 16'h0000);
    rd(5'd31, v); check("R8 index 31 reads zero", v, 16'h0000);
    rd(5'd16, v); check("R8 override not consumed", v, extExp(1'b1, 5'd7, 3'b100));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_bits();
    t_locked();
    t_oneshot_id();
    t_status();
    t_addr();
    t_unimpl();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule